// File: doc/BRIEF.md
# DMA Channel Extended-Command Register File

This block is the host-facing register front end of a sixteen-channel DMA controller. The host sees only two byte-wide I/O locations. One is the command location, where a byte carries a function code in its upper nibble and a channel number in its lower nibble. The other is the data location. Through it, successive bytes go into, or come out of, whichever channel register the last command selected. An internal byte pointer steps forward on every access.

Each channel holds a 24-bit transfer address, a 16-bit count (the transfer length minus one), a mode byte and an enable flag. All of these values are presented in parallel to the transfer engine. To set up a channel, the driver issues a short fixed sequence: disable, load the address, load the count, load the mode, enable.

Top module: `dma_xcmd_regfile`

## Requirements
- R1: Only an I/O write at offset 0x18 is taken as a command, and only an access at offset 0x1A reaches the data port. A write to any other offset changes nothing.
- R2: Command 0xA0 plus n sets the enable flag of channel n, and command 0x90 plus n clears it. The enable flags of all other channels are unchanged.
- R3: Command 0x20 plus n selects the address of channel n and zeroes the byte pointer. The next three data writes load address bits 7:0, then 15:8, then 23:16. No other channel changes.
- R4: Command 0x40 plus n selects the 16-bit count of channel n and zeroes the pointer. The next two data writes load bits 7:0, then 15:8. The stored value is the transfer length minus one, so writing 0xFF then 0x01 describes a 512-byte transfer.
- R5: Command 0x70 plus n selects the mode byte of channel n. The next data write stores it unchanged (for example 0x4C for device-to-memory, 0x44 for memory-to-device).
- R6: Once the last byte of the selected register has been written, further data writes leave every register unchanged until a new select command.
- R7: A command byte whose upper nibble is not 0x2, 0x4, 0x7, 0x9 or 0xA changes no channel state, no selection and no byte pointer.
- R8: A data-port read returns the selected register byte at the pointer and advances the pointer, in the same byte order as writes. The byte appears on the read data output one cycle after the read strobe and holds there. A read past the last byte, a read with nothing selected, and a read of the command offset all return 0x00. Reads never change stored values.
- R9: Reset clears every enable flag, address, count and mode byte, and leaves no register selected. A data write after reset and before any select command has no effect.
- R10: Enable and disable commands do not disturb the current selection or byte pointer. A multi-byte load may therefore be interrupted by one and then continued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O offset of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte (ignored when io_wr is high) |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, registered |
| ch_en_o | output | 16 | Enable flag per channel |
| ch_addr_o | output | 384 | Channel addresses, channel n at bits 24n+23:24n |
| ch_cnt_o | output | 256 | Channel counts, channel n at bits 16n+15:16n |
| ch_mode_o | output | 128 | Channel mode bytes, channel n at bits 8n+7:8n |

## Verification
Every result is registered once. A command or data write appears on the channel outputs after the clock edge that samples the strobe. A read byte appears on io_rdata after the edge that samples the read strobe. The bench therefore drives each strobe for exactly one cycle, starting on a falling edge, and samples on the next falling edge, by which time that single edge has passed. It then leaves one idle cycle before the next access, so the results of consecutive accesses never overlap.

// File: rtl/xcmd_pkg.sv
package xcmd_pkg;

    localparam logic [3:0] FN_ADDR = 4'h2;
    localparam logic [3:0] FN_CNT  = 4'h4;
    localparam logic [3:0] FN_MODE = 4'h7;
    localparam logic [3:0] FN_OFF  = 4'h9;
    localparam logic [3:0] FN_ON   = 4'hA;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ADDR,
        OP_CNT,
        OP_MODE,
        OP_OFF,
        OP_ON
    } op_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_CNT,
        SEL_MODE
    } sel_e;

endpackage

// File: rtl/xcmd_decode.sv
module xcmd_decode
    import xcmd_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CH_W   = 4
) (
    input  logic [7:0]      cmd_byte,
    output op_e             op,
    output logic [CH_W-1:0] chan
);

    logic [3:0] fn;
    logic [3:0] ch_nib;

    always_comb begin
        fn     = cmd_byte[7:4];
        ch_nib = cmd_byte[3:0];
        chan   = ch_nib[CH_W-1:0];
        case (fn)
            FN_ADDR: op = OP_ADDR;
            FN_CNT:  op = OP_CNT;
            FN_MODE: op = OP_MODE;
            FN_OFF:  op = OP_OFF;
            FN_ON:   op = OP_ON;
            default: op = OP_NOP;
        endcase
        // channel numbers beyond the implemented count are dropped
        if (32'(ch_nib) >= NUM_CH) begin
            op = OP_NOP;
        end
    end

endmodule

// File: rtl/xcmd_ptr.sv
module xcmd_ptr
    import xcmd_pkg::*;
#(
    parameter int unsigned CH_W       = 4,
    parameter int unsigned ADDR_BYTES = 3,
    parameter int unsigned CNT_BYTES  = 2,
    parameter int unsigned PTR_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  op_e             op,
    input  logic [CH_W-1:0] cmd_chan,
    input  logic            data_acc,
    output sel_e            sel,
    output logic [CH_W-1:0] chan,
    output logic [PTR_W-1:0] ptr,
    output logic            live
);

    typedef struct packed {
        sel_e             sel;
        logic [CH_W-1:0]  chan;
        logic [PTR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t          st_d, st_q;
    logic [PTR_W-1:0] len;

    always_comb begin
        case (st_q.sel)
            SEL_ADDR: len = PTR_W'(ADDR_BYTES);
            SEL_CNT:  len = PTR_W'(CNT_BYTES);
            SEL_MODE: len = PTR_W'(1);
            default:  len = '0;
        endcase
    end

    assign live = (st_q.ptr < len);

    always_comb begin
        st_d = st_q;
        if (cmd_wr && (op == OP_ADDR || op == OP_CNT || op == OP_MODE)) begin
            st_d.chan = cmd_chan;
            st_d.ptr  = '0;
            case (op)
                OP_ADDR: st_d.sel = SEL_ADDR;
                OP_CNT:  st_d.sel = SEL_CNT;
                default: st_d.sel = SEL_MODE;
            endcase
        end else if (data_acc && live) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sel: SEL_NONE, chan: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel  = st_q.sel;
    assign chan = st_q.chan;
    assign ptr  = st_q.ptr;

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= len); // R6

    AST_UNKNOWN_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op == OP_NOP) |=> $stable(st_q)); // R7

    AST_ENABLE_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (op == OP_ON || op == OP_OFF)) |=> $stable(st_q)); // R10

endmodule

// File: rtl/xcmd_bank.sv
module xcmd_bank
    import xcmd_pkg::*;
#(
    parameter int unsigned NUM_CH     = 16,
    parameter int unsigned CH_W       = 4,
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned MODE_W     = 8,
    parameter int unsigned PTR_W      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  sel_e                     sel,
    input  logic [CH_W-1:0]          chan,
    input  logic [PTR_W-1:0]         ptr,
    input  logic [7:0]               wdata,
    input  logic                     on_vld,
    input  logic                     off_vld,
    input  logic [CH_W-1:0]          cmd_chan,
    output logic [NUM_CH-1:0]        en_o,
    output logic [NUM_CH*ADDR_W-1:0] addr_o,
    output logic [NUM_CH*CNT_W-1:0]  cnt_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [7:0]               rd_byte
);

    localparam int unsigned ADDR_BYTES = ADDR_W / 8;
    localparam int unsigned CNT_BYTES  = CNT_W / 8;

    typedef struct packed {
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0][ADDR_W-1:0] addr;
        logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
        logic [NUM_CH-1:0][MODE_W-1:0] mode;
    } bank_t;

    bank_t             st_d, st_q;
    logic [NUM_CH-1:0] on_hit, off_hit, wr_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign on_hit[g]  = on_vld  && (cmd_chan == CH_W'(g));
        assign off_hit[g] = off_vld && (cmd_chan == CH_W'(g));
        assign wr_hit[g]  = wr_en   && (chan == CH_W'(g));

        AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            on_hit[g] |=> st_q.en[g]); // R2

        AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            off_hit[g] |=> !st_q.en[g]); // R2

        AST_OTHER_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit[g] |=> ($stable(st_q.addr[g]) && $stable(st_q.cnt[g])
                            && $stable(st_q.mode[g]))); // R3
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (on_hit[i]) begin
                st_d.en[i] = 1'b1;
            end
            if (off_hit[i]) begin
                st_d.en[i] = 1'b0;
            end
            if (wr_hit[i]) begin
                case (sel)
                    SEL_ADDR: begin
                        for (int k = 0; k < ADDR_BYTES; k++) begin
                            if (ptr == PTR_W'(k)) begin
                                st_d.addr[i][8*k +: 8] = wdata;
                            end
                        end
                    end
                    SEL_CNT: begin
                        for (int k = 0; k < CNT_BYTES; k++) begin
                            if (ptr == PTR_W'(k)) begin
                                st_d.cnt[i][8*k +: 8] = wdata;
                            end
                        end
                    end
                    SEL_MODE: begin
                        if (ptr == '0) begin
                            st_d.mode[i] = wdata[MODE_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        case (sel)
            SEL_ADDR: begin
                for (int k = 0; k < ADDR_BYTES; k++) begin
                    if (ptr == PTR_W'(k)) begin
                        rd_byte = st_q.addr[chan][8*k +: 8];
                    end
                end
            end
            SEL_CNT: begin
                for (int k = 0; k < CNT_BYTES; k++) begin
                    if (ptr == PTR_W'(k)) begin
                        rd_byte = st_q.cnt[chan][8*k +: 8];
                    end
                end
            end
            SEL_MODE: rd_byte = 8'(st_q.mode[chan]);
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign addr_o = st_q.addr;
    assign cnt_o  = st_q.cnt;
    assign mode_o = st_q.mode;

endmodule

// File: rtl/dma_xcmd_regfile.sv
module dma_xcmd_regfile
    import xcmd_pkg::*;
#(
    parameter int unsigned NUM_CH    = 16,
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned MODE_W    = 8,
    parameter int unsigned IO_AW     = 8,
    parameter logic [7:0]  CMD_PORT  = 8'h18,
    parameter logic [7:0]  DATA_PORT = 8'h1A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IO_AW-1:0]         io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    output logic [NUM_CH-1:0]        ch_en_o,
    output logic [NUM_CH*ADDR_W-1:0] ch_addr_o,
    output logic [NUM_CH*CNT_W-1:0]  ch_cnt_o,
    output logic [NUM_CH*MODE_W-1:0] ch_mode_o
);

    localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned ADDR_BYTES = ADDR_W / 8;
    localparam int unsigned CNT_BYTES  = CNT_W / 8;
    localparam int unsigned PTR_W      = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic [7:0] rdata;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             cmd_wr, data_wr, data_rd, live;
    op_e              op;
    logic [CH_W-1:0]  dec_chan, sel_chan;
    sel_e             sel;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       rd_byte;

    assign cmd_wr  = io_wr && (io_addr == IO_AW'(CMD_PORT));
    assign data_wr = io_wr && (io_addr == IO_AW'(DATA_PORT));
    assign data_rd = io_rd && !io_wr && (io_addr == IO_AW'(DATA_PORT));

    xcmd_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_decode (
        .cmd_byte (io_wdata),
        .op       (op),
        .chan     (dec_chan)
    );

    xcmd_ptr #(
        .CH_W       (CH_W),
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_BYTES  (CNT_BYTES),
        .PTR_W      (PTR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .op       (op),
        .cmd_chan (dec_chan),
        .data_acc (data_wr || data_rd),
        .sel      (sel),
        .chan     (sel_chan),
        .ptr      (ptr),
        .live     (live)
    );

    xcmd_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .MODE_W (MODE_W),
        .PTR_W  (PTR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr && live),
        .sel      (sel),
        .chan     (sel_chan),
        .ptr      (ptr),
        .wdata    (io_wdata),
        .on_vld   (cmd_wr && op == OP_ON),
        .off_vld  (cmd_wr && op == OP_OFF),
        .cmd_chan (dec_chan),
        .en_o     (ch_en_o),
        .addr_o   (ch_addr_o),
        .cnt_o    (ch_cnt_o),
        .mode_o   (ch_mode_o),
        .rd_byte  (rd_byte)
    );

    always_comb begin
        st_d = st_q;
        if (io_rd && !io_wr) begin
            st_d.rdata = (data_rd && live) ? rd_byte : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rdata = st_q.rdata;

    AST_EXHAUSTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !live) |=> ($stable(ch_addr_o) && $stable(ch_cnt_o)
                                && $stable(ch_mode_o))); // R6

    AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && op == OP_NOP) |=> ($stable(ch_en_o) && $stable(ch_addr_o)
                                      && $stable(ch_cnt_o) && $stable(ch_mode_o))); // R7

    AST_READ_PURE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr) |=> ($stable(ch_en_o) && $stable(ch_addr_o)
                               && $stable(ch_cnt_o) && $stable(ch_mode_o))); // R8

    AST_FOREIGN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !data_wr) |=> ($stable(ch_en_o) && $stable(ch_addr_o)
                                   && $stable(ch_cnt_o) && $stable(ch_mode_o))); // R1

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch_en_o == '0 && ch_addr_o == '0)); // R9

endmodule

// File: tb/dma_xcmd_regfile_bench.sv
module dma_xcmd_regfile_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = 8'h00;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_wdata = 8'h00;
    logic [7:0]   io_rdata;
    logic [15:0]  ch_en_o;
    logic [383:0] ch_addr_o;
    logic [255:0] ch_cnt_o;
    logic [127:0] ch_mode_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_xcmd_regfile u_dma_xcmd_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .ch_en_o   (ch_en_o),
        .ch_addr_o (ch_addr_o),
        .ch_cnt_o  (ch_cnt_o),
        .ch_mode_o (ch_mode_o)
    );

    // entry: {is_read, requirement number, offset, write data or expected read}
    localparam int NV = 26;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd3, 8'h18, 8'h23},  // R3 select address ch3
        {1'b0, 4'd3, 8'h1A, 8'h12},
        {1'b0, 4'd3, 8'h1A, 8'h34},
        {1'b0, 4'd3, 8'h1A, 8'h56},
        {1'b0, 4'd6, 8'h1A, 8'hEE},  // R6 extra byte dropped
        {1'b0, 4'd8, 8'h18, 8'h23},  // R8 reselect, read back
        {1'b1, 4'd8, 8'h1A, 8'h12},
        {1'b1, 4'd8, 8'h1A, 8'h34},
        {1'b1, 4'd8, 8'h1A, 8'h56},
        {1'b1, 4'd8, 8'h1A, 8'h00},  // R8 past the end
        {1'b0, 4'd4, 8'h18, 8'h45},  // R4 count ch5
        {1'b0, 4'd4, 8'h1A, 8'hFF},
        {1'b0, 4'd4, 8'h1A, 8'h01},
        {1'b0, 4'd4, 8'h18, 8'h45},
        {1'b1, 4'd4, 8'h1A, 8'hFF},
        {1'b1, 4'd4, 8'h1A, 8'h01},
        {1'b1, 4'd6, 8'h1A, 8'h00},
        {1'b0, 4'd5, 8'h18, 8'h7F},  // R5 mode ch15
        {1'b0, 4'd5, 8'h1A, 8'h4C},
        {1'b0, 4'd5, 8'h18, 8'h7F},
        {1'b1, 4'd5, 8'h1A, 8'h4C},
        {1'b0, 4'd5, 8'h18, 8'h70},  // R5 mode ch0
        {1'b0, 4'd5, 8'h1A, 8'h44},
        {1'b0, 4'd5, 8'h18, 8'h70},
        {1'b1, 4'd5, 8'h1A, 8'h44},
        {1'b1, 4'd8, 8'h18, 8'h00}   // R8 command offset reads zero
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", 32'(ch_en_o), 32'h0);
        chk("R9", 32'(|ch_addr_o | |ch_cnt_o | |ch_mode_o), 32'h0);
        chk("R9", 32'(io_rdata), 32'h0);
        wr(8'h1A, 8'h77);
        chk("R9", 32'(|ch_addr_o | |ch_cnt_o | |ch_mode_o), 32'h0);
        rd(8'h1A, rv);
        chk("R8", 32'(rv), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                rd(VEC[i][15:8], rv);
                chk($sformatf("R%0d", VEC[i][19:16]), 32'(rv), 32'(VEC[i][7:0]));
            end else begin
                wr(VEC[i][15:8], VEC[i][7:0]);
            end
        end
        chk("R3", 32'(ch_addr_o[3*24 +: 24]), 32'h563412);
        chk("R6", 32'(ch_addr_o[2*24 +: 24]), 32'h0);
        chk("R4", 32'(ch_cnt_o[5*16 +: 16]), 32'h01FF);
        chk("R5", 32'(ch_mode_o[15*8 +: 8]), 32'h4C);
        chk("R5", 32'(ch_mode_o[0 +: 8]), 32'h44);

        // R2 enable and disable
        wr(8'h18, 8'hA2);
        wr(8'h18, 8'hA9);
        chk("R2", 32'(ch_en_o), 32'h0204);
        wr(8'h18, 8'h92);
        chk("R2", 32'(ch_en_o), 32'h0200);

        // R7 unknown commands keep selection, pointer and state
        wr(8'h18, 8'h46);
        wr(8'h1A, 8'h11);
        wr(8'h18, 8'hB6);
        wr(8'h18, 8'h00);
        wr(8'h18, 8'hF3);
        chk("R7", 32'(ch_en_o), 32'h0200);
        wr(8'h1A, 8'h22);
        chk("R7", 32'(ch_cnt_o[6*16 +: 16]), 32'h2211);

        // R10 enable in the middle of an address load
        wr(8'h18, 8'h21);
        wr(8'h1A, 8'hAA);
        wr(8'h18, 8'hA1);
        wr(8'h1A, 8'hBB);
        wr(8'h1A, 8'hCC);
        chk("R10", 32'(ch_addr_o[1*24 +: 24]), 32'hCCBBAA);
        chk("R10", 32'(ch_en_o), 32'h0202);

        // R1 foreign offsets
        wr(8'h19, 8'hA4);
        chk("R1", 32'(ch_en_o), 32'h0202);
        wr(8'h18, 8'h74);
        wr(8'h1B, 8'h99);
        chk("R1", 32'(ch_mode_o[4*8 +: 8]), 32'h0);
        wr(8'h1A, 8'h44);
        chk("R1", 32'(ch_mode_o[4*8 +: 8]), 32'h44);

        // R6 fourth address byte on another channel
        wr(8'h18, 8'h27);
        wr(8'h1A, 8'h01);
        wr(8'h1A, 8'h02);
        wr(8'h1A, 8'h03);
        wr(8'h1A, 8'h04);
        chk("R6", 32'(ch_addr_o[7*24 +: 24]), 32'h030201);

        // R9 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", 32'(ch_en_o), 32'h0);
        chk("R9", 32'(|ch_addr_o | |ch_cnt_o | |ch_mode_o), 32'h0);
        wr(8'h1A, 8'h5A);
        rd(8'h1A, rv);
        chk("R9", 32'(rv), 32'h0);
        chk("R9", 32'(|ch_addr_o | |ch_cnt_o | |ch_mode_o), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule